// File: doc/BRIEF.md
# Oversampled SPI Mode-0 Slave

This block is an SPI slave for mode 0 (clock idle low, data captured on the rising clock edge) that runs entirely in the system clock domain. The serial clock, the select and the incoming data line are treated as ordinary asynchronous inputs. Each of them passes through a synchroniser chain. Clock edges are then found by comparing consecutive synchronised samples, so no logic is ever clocked by the serial clock.

On the user side, the byte to send next is offered with a valid/ready handshake and held in a one-word buffer. That buffer is fetched into the transmit shifter when the select is first seen low, and again at every word boundary while the select stays low. Every complete byte shifted in from the master appears on a parallel output together with a one-cycle valid pulse. Words are 8 bits wide by default and travel MSB first in both directions. The system clock must run at roughly ten or more times the serial clock rate.

The controller has three states. `SS_IDLE` holds while the select is high. The transition *select seen* leads to `SS_LOAD`, which fetches the first transmit word in a single cycle. The transition *load done* then leads to `SS_SHIFT`, where bits move on the detected edges. The transition *select released* returns `SS_LOAD` or `SS_SHIFT` to `SS_IDLE` and clears the bit counter.

Top module: `sclk_sampled_slave`

## Requirements
- R1: After a synchronous active-high reset, `tx_ready` is 1, `rx_valid` is 0 and `spi_miso` is 0.
- R2: While the select is low, `spi_mosi` is sampled on each detected rising edge of `spi_sclk`, MSB first. After the eighth rising edge of a word, `rx_data` holds the byte and `rx_valid` is 1 for exactly one cycle. `rx_data` changes only in a cycle where `rx_valid` is 1.
- R3: A transmit byte is accepted in the cycle where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until the byte is fetched into the shifter. A `tx_valid` pulse while `tx_ready` is 0 stores nothing.
- R4: The fetched byte is driven on `spi_miso` MSB first. Its first bit is present shortly after the select is seen low, and each later bit replaces the previous one on a detected falling edge of `spi_sclk`.
- R5: When no byte is held at a fetch, the word sent on `spi_miso` is 0x00.
- R6: While the select stays low, the falling edge that follows the eighth rising edge of a word fetches the next transmit byte, so consecutive words flow without gaps.
- R7: If the select goes high partway through a word, the bit counter clears and no `rx_valid` is produced. The next selection starts a fresh word.
- R8: While the select is high, activity on `spi_sclk` and `spi_mosi` is ignored. `spi_miso` is 0 and no `rx_valid` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | Serial clock from the master, asynchronous |
| spi_cs_n | input | 1 | Select from the master, active low, asynchronous |
| spi_mosi | input | 1 | Serial data from the master, asynchronous |
| spi_miso | output | 1 | Serial data to the master |
| tx_data | input | WORD_W | Next byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | The transmit buffer is empty and can accept a byte |
| rx_data | output | WORD_W | Last complete byte received |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_data` |

## Verification
The bench uses the default build, with `WORD_W` = 8 and `SYNC_STAGES` = 2. It drives the serial clock with a half period of 8 system cycles, which gives a 16:1 oversampling ratio. At that ratio every edge clears the three-to-four cycle synchroniser and detector latency with margin, so both the word-boundary fetch inside a multi-word burst and an abort after four bits can be placed at exact positions. The short synchroniser also keeps the deselect window watched by the checker to four cycles.

// File: rtl/sss_pkg.sv
package sss_pkg;

    typedef enum logic [1:0] {
        SS_IDLE  = 2'd0,
        SS_LOAD  = 2'd1,
        SS_SHIFT = 2'd2
    } sss_state_e;

endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sss_edge.sv
module sss_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

endmodule

// File: rtl/sss_txpath.sv
module sss_txpath #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              fetch,
    input  logic              shift,
    output logic              tx_ready,
    output logic              bit_out
);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shreg_q;
    logic              full_q;

    // holding buffer and handshake
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (tx_valid && !full_q) begin
            hold_q <= tx_data;
            full_q <= 1'b1;
        end else if (fetch) begin
            full_q <= 1'b0;
        end
    end

    // output shifter, empty buffer sends zeros
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (fetch) begin
            shreg_q <= full_q ? hold_q : '0;
        end else if (shift) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
        end
    end

    assign tx_ready = ~full_q;
    assign bit_out  = shreg_q[WORD_W-1];

endmodule

// File: rtl/sss_rxpath.sv
module sss_rxpath #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              bit_in,
    input  logic              word_end,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);

    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] next_word;

    assign next_word = {shreg_q[WORD_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample) begin
                shreg_q <= next_word;
                if (word_end) begin
                    rx_data  <= next_word;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sclk_sampled_slave.sv
module sclk_sampled_slave
    import sss_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int                CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(WORD_W - 1);

    logic sclk_s, csn_s, mosi_s;
    logic sclk_rise, sclk_fall;
    logic fetch, shift, sample, word_end;
    logic tx_bit;
    logic [CNT_W-1:0] bit_cnt_q;

    sss_state_e state_q, state_d;

    sss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .d(spi_sclk), .q(sclk_s)
    );
    sss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst(rst), .d(spi_cs_n), .q(csn_s)
    );
    sss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst(rst), .d(spi_mosi), .q(mosi_s)
    );

    sss_edge u_edge (
        .clk(clk), .rst(rst), .level(sclk_s),
        .rise(sclk_rise), .fall(sclk_fall)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SS_IDLE;
        else     state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d  = state_q;
        fetch    = 1'b0;
        shift    = 1'b0;
        sample   = 1'b0;
        word_end = 1'b0;
        spi_miso = 1'b0;
        unique case (state_q)
            SS_IDLE: begin
                if (!csn_s) state_d = SS_LOAD;            // select seen
            end
            SS_LOAD: begin
                fetch = 1'b1;
                if (csn_s) state_d = SS_IDLE;             // select released
                else       state_d = SS_SHIFT;            // load done
            end
            SS_SHIFT: begin
                spi_miso = tx_bit;
                if (csn_s) begin
                    state_d = SS_IDLE;                    // select released
                end else begin
                    sample   = sclk_rise;
                    word_end = sclk_rise && (bit_cnt_q == CNT_LAST);
                    fetch    = sclk_fall && (bit_cnt_q == '0);
                    shift    = sclk_fall && (bit_cnt_q != '0);
                end
            end
            default: state_d = SS_IDLE;
        endcase
    end

    // bit position within the current word
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt_q <= '0;
        end else if (state_q != SS_SHIFT || csn_s) begin
            bit_cnt_q <= '0;
        end else if (sample) begin
            bit_cnt_q <= (bit_cnt_q == CNT_LAST) ? '0 : bit_cnt_q + 1'b1;
        end
    end

    sss_txpath #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst(rst),
        .tx_data(tx_data), .tx_valid(tx_valid),
        .fetch(fetch), .shift(shift),
        .tx_ready(tx_ready), .bit_out(tx_bit)
    );

    sss_rxpath #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst(rst),
        .sample(sample), .bit_in(mosi_s), .word_end(word_end),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

endmodule

// File: rtl/sss_chk.sv
module sss_chk #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_valid
);

    localparam int HI_LIMIT = SYNC_STAGES + 2;

    logic [4:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !spi_cs_n) hi_cnt <= '0;
        else if (hi_cnt != 5'd31) hi_cnt <= hi_cnt + 5'd1;
    end

    // R2
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R2
    rx_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_data));

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R8
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(hi_cnt) >= HI_LIMIT) |-> (!spi_miso && !rx_valid));

endmodule

bind sclk_sampled_slave sss_chk #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid)
);

// File: tb/sim_sclk_sampled_slave.sv
module sim_sclk_sampled_slave;

    localparam int W    = 8;
    localparam int HALF = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, tx_valid = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic miso, tx_ready, rx_valid;
    logic [W-1:0] rx_data;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] exp_item;
    logic prev_vld = 1'b0;

    always #10 clk = ~clk;

    sclk_sampled_slave #(.WORD_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop on each received byte
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid && prev_vld) chk(1'b0, "R2 valid pulse width", 8'd1, 8'd0);
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7/R8 unexpected rx_valid", rx_data, 8'd0);
                end else begin
                    exp_item = exp_q.pop_front();
                    chk(rx_data == exp_item, "R2 received byte", rx_data, exp_item);
                end
            end
        end
        prev_vld <= rx_valid;
    end

    task automatic load_byte(input logic [W-1:0] b);
        while (!tx_ready) @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R3 ready drops after accept", W'(tx_ready), 8'd0);
    endtask

    task automatic select_dev();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic deselect_dev();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    // driver: one word, pushes the expected received byte
    task automatic xfer(input logic [W-1:0] tx, input logic [W-1:0] exp_miso, input string req);
        logic [W-1:0] got;
        got = '0;
        exp_q.push_back(tx);
        for (int i = W-1; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            got[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        chk(got == exp_miso, req, got, exp_miso);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_ready == 1'b1, "R1 tx_ready after reset", W'(tx_ready), 8'd1);
        chk(rx_valid == 1'b0, "R1 rx_valid after reset", W'(rx_valid), 8'd0);
        chk(miso == 1'b0, "R1 miso after reset", W'(miso), 8'd0);

        // R4 single word with a loaded byte
        load_byte(8'hA5);
        select_dev();
        xfer(8'h3C, 8'hA5, "R4 MISO byte A5");
        deselect_dev();

        // R5 nothing loaded
        select_dev();
        xfer(8'hFF, 8'h00, "R5 empty buffer sends 00");
        deselect_dev();

        // R3 offer while not ready is ignored
        load_byte(8'h11);
        tx_data  = 8'h22;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R3 ready stays low while full", W'(tx_ready), 8'd0);
        select_dev();
        xfer(8'h81, 8'h11, "R3 first byte kept");
        deselect_dev();
        select_dev();
        xfer(8'h00, 8'h00, "R3 rejected byte not stored");
        deselect_dev();

        // R6 burst of three words in one selection
        load_byte(8'hC3);
        select_dev();
        load_byte(8'h96);
        xfer(8'h12, 8'hC3, "R6 burst word 1");
        xfer(8'h34, 8'h96, "R6 burst word 2");
        xfer(8'h56, 8'h00, "R6 burst word 3 empty");
        deselect_dev();

        // R7 abort after four bits, then a fresh word
        select_dev();
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        deselect_dev();
        chk(exp_q.size() == 0, "R7 no byte from aborted word", W'(exp_q.size()), 8'd0);
        select_dev();
        xfer(8'h5A, 8'h00, "R7 word after abort");
        deselect_dev();

        // R8 clock activity while deselected
        for (int i = 0; i < W; i++) begin
            mosi = i[0];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            chk(miso == 1'b0, "R8 miso low while deselected", W'(miso), 8'd0);
            sclk = 1'b0;
        end
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected bytes delivered", W'(exp_q.size()), 8'd0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule